// File: doc/BRIEF.md
# Sync-Word Gated Receive FIFO

This block sits behind a demodulator and watches a serial bit stream one bit per accepted beat. While filling is armed it slides each new bit into a 16-bit window and compares the window with a two-byte synchronization word. The upper byte of that word is fixed by a parameter, and the lower byte can be programmed. Once the word is seen, every following group of eight bits is assembled into a byte, most significant bit first, and stored in a 16-entry receive queue.

A host controls the block and drains the queue with 16-bit command frames on an SPI mode-0 port. The host clock is oversampled by the system clock through synchronizers. The upper byte of each frame selects the action. A read frame returns the oldest stored byte on MISO during its lower eight bit times. An interrupt line stays high while data is waiting, and a sticky flag records any byte that was lost to a full queue.

The bit input is a valid/ready stream, but the block never back-pressures it: ready is held high. A bit is taken on every clock edge where valid is high. If the queue is full when a byte completes, that byte is dropped instead of stalling the stream.

Top module: `sync_rx_fifo`

## Requirements
- R1: After reset the programmable pattern byte is D4h, fill and queue-enable are both off, and `irq`, `ovf` and MISO are low.
- R2: A frame with upper byte CEh loads its lower byte as the low half of the sync word. The full word is {2Dh, low byte}, and received bits are compared MSB first.
- R3: A frame with upper byte CAh sets fill-enable from bit 1 and queue-enable from bit 0 of its lower byte. While fill is armed, no byte is stored until the 16 most recent accepted bits equal the sync word.
- R4: After a match, each following 8 accepted bits form one byte, first bit in the MSB, and that byte is written to the queue.
- R5: Clearing fill-enable stops filling at once. A partly assembled byte is discarded, and later bits are ignored.
- R6: Rewriting fill-enable as 1 while filling does not restart the search, and data keeps packing. A new search starts only after fill-enable is cleared and then set again.
- R7: Frame B000h shifts the oldest queued byte out on MISO, MSB first, during bit times 9 to 16, and removes that byte from the queue.
- R8: A read frame returns 00h and removes nothing when queue-enable is clear or the queue is empty.
- R9: `irq` is high exactly while the queue holds at least one byte.
- R10: The queue holds 16 bytes. A byte completed while the queue is full is discarded, and it sets `ovf`, which stays high until reset.
- R11: `bit_ready` is always high, so every cycle with `bit_valid` high consumes one bit.
- R12: Frames with any other upper byte change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Received bit is present |
| bit_data | input | 1 | Received bit value |
| bit_ready | output | 1 | Always high; the stream is never stalled |
| spi_sck | input | 1 | Host serial clock, mode 0 |
| spi_csn | input | 1 | Host frame select, active low |
| spi_mosi | input | 1 | Host command bits, MSB first |
| spi_miso | output | 1 | Read data to the host |
| irq | output | 1 | Queue not empty |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that SCK stays high and low for at least four system clocks per phase, and that MOSI is stable across each rising SCK edge. They also assume that a frame carries sixteen SCK pulses between falling and rising CSN. Under these conditions the synchronized edges are seen once each, and the read pop is never issued against an empty queue. The stimulus holds every SCK phase for six clocks, changes MOSI only while SCK is low, and idles CSN between frames. Bits are offered one beat at a time with no overlap with host frames, so queue contents can be predicted arithmetically.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int FRAME_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_PATTERN = 8'hCE;
  localparam logic [BYTE_W-1:0] OP_CONTROL = 8'hCA;
  localparam logic [BYTE_W-1:0] OP_READ    = 8'hB0;

  localparam int CTL_FILL_BIT = 1;
  localparam int CTL_QUEUE_BIT = 0;

  typedef enum logic [1:0] {
    HUNT_IDLE   = 2'd0,
    HUNT_SEARCH = 2'd1,
    HUNT_FILL   = 2'd2
  } hunt_state_e;
endpackage

// File: rtl/syncword_hunter.sv
module syncword_hunter
  import sync_rx_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] SYNC_HI = 8'h2D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill_en,
  input  logic [W-1:0] pat_lo,
  input  logic         bit_valid,
  input  logic         bit_data,
  output logic         byte_push,
  output logic [W-1:0] byte_data
);
  localparam int SW = 2 * W;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  hunt_state_e state;
  logic [SW-1:0] window;
  logic [SW-1:0] window_nx;
  logic [W-1:0]  pack;
  logic [CW-1:0] nbits;
  logic          hit;

  assign window_nx = {window[SW-2:0], bit_data};
  assign hit       = (window_nx == {SYNC_HI, pat_lo});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= HUNT_IDLE;
      window    <= '0;
      pack      <= '0;
      nbits     <= '0;
      byte_push <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_push <= 1'b0;
      case (state)
        HUNT_IDLE: begin
          window <= '0;
          nbits  <= '0;
          if (fill_en) state <= HUNT_SEARCH;
        end
        HUNT_SEARCH: begin
          if (!fill_en) begin
            state <= HUNT_IDLE;
          end else if (bit_valid) begin
            window <= window_nx;
            if (hit) begin
              state <= HUNT_FILL;
              nbits <= '0;
            end
          end
        end
        HUNT_FILL: begin
          if (!fill_en) begin
            state <= HUNT_IDLE;
            nbits <= '0;
          end else if (bit_valid) begin
            pack <= {pack[W-2:0], bit_data};
            if (nbits == LAST) begin
              byte_push <= 1'b1;
              byte_data <= {pack[W-2:0], bit_data};
              nbits     <= '0;
            end else begin
              nbits <= nbits + 1'b1;
            end
          end
        end
        default: state <= HUNT_IDLE;
      endcase
    end
  end

  // R3: the search cannot succeed without a new bit
  a_r3_no_match_without_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HUNT_SEARCH && !bit_valid) |=> (state != HUNT_FILL));

  // R5: dropping fill-enable always returns to idle
  a_r5_stop_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> (state == HUNT_IDLE));

  // R4: bytes need several bits each, so pushes never come back to back
  a_r4_push_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    byte_push |=> !byte_push);
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          wr_ok, rd_ok;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign rd_ok = pop && !empty;
  assign wr_ok = push && (!full || rd_ok);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !wr_ok) ovf <= 1'b1;
    end
  end

  // R10: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R10: the overflow flag is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R9: a lone push into a non-full queue raises occupancy by one
  a_r9_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import sync_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PAT_RESET = 8'hD4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] q_head,
  input  logic              q_empty,
  output logic              miso,
  output logic              q_pop,
  output logic [BYTE_W-1:0] pat_lo,
  output logic              fill_en,
  output logic              queue_en
);
  localparam int CW = $clog2(FRAME_W) + 1;
  localparam logic [CW-1:0] HDR_LAST = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] FRM_LAST = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] FRM_DONE = CW'(FRAME_W);
  localparam logic [CW-1:0] HDR_DONE = CW'(BYTE_W);

  logic [2:0] sck_p;
  logic [1:0] csn_p, mosi_p;
  logic       sck_s, sck_d, csn_s, mosi_s, rise, fall;
  logic [FRAME_W-2:0] shreg;
  logic [FRAME_W-1:0] word;
  logic [CW-1:0]      nrise;
  logic [BYTE_W-1:0]  out_sr;

  assign sck_s  = sck_p[1];
  assign sck_d  = sck_p[2];
  assign csn_s  = csn_p[1];
  assign mosi_s = mosi_p[1];
  assign rise   = sck_s && !sck_d;
  assign fall   = !sck_s && sck_d;
  assign word   = {shreg, mosi_s};
  assign miso   = out_sr[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck};
      csn_p  <= {csn_p[0], csn};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      nrise    <= '0;
      out_sr   <= '0;
      q_pop    <= 1'b0;
      pat_lo   <= PAT_RESET;
      fill_en  <= 1'b0;
      queue_en <= 1'b0;
    end else begin
      q_pop <= 1'b0;
      if (csn_s) begin
        nrise  <= '0;
        out_sr <= '0;
      end else if (rise && nrise != FRM_DONE) begin
        shreg <= word[FRAME_W-2:0];
        nrise <= nrise + 1'b1;
        if (nrise == HDR_LAST && word[BYTE_W-1:0] == OP_READ) begin
          if (queue_en && !q_empty) begin
            out_sr <= q_head;
            q_pop  <= 1'b1;
          end else begin
            out_sr <= '0;
          end
        end
        if (nrise == FRM_LAST) begin
          case (word[FRAME_W-1:BYTE_W])
            OP_PATTERN: pat_lo <= word[BYTE_W-1:0];
            OP_CONTROL: begin
              fill_en  <= word[CTL_FILL_BIT];
              queue_en <= word[CTL_QUEUE_BIT];
            end
            default: ;
          endcase
        end
      end else if (fall && nrise > HDR_DONE) begin
        out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R8: a pop is only issued while the queue is enabled
  a_r8_pop_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> queue_en);

  // R7: outside a frame the read line is quiet
  a_r7_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso);
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter logic [BYTE_W-1:0] SYNC_HI = 8'h2D,
  parameter logic [BYTE_W-1:0] PAT_RESET = 8'hD4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  input  logic spi_sck,
  input  logic spi_csn,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic irq,
  output logic ovf
);
  logic              fill_en, queue_en;
  logic [BYTE_W-1:0] pat_lo;
  logic              push, pop, q_empty, q_full;
  logic [BYTE_W-1:0] push_data, q_head;

  assign bit_ready = 1'b1;
  assign irq       = !q_empty;

  syncword_hunter #(.W(BYTE_W), .SYNC_HI(SYNC_HI)) u_hunt (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .pat_lo(pat_lo),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .byte_push(push), .byte_data(push_data)
  );

  rx_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .head(q_head), .empty(q_empty), .full(q_full), .ovf(ovf)
  );

  spi_cmd_port #(.PAT_RESET(PAT_RESET)) u_spi (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .q_head(q_head), .q_empty(q_empty), .miso(spi_miso), .q_pop(pop),
    .pat_lo(pat_lo), .fill_en(fill_en), .queue_en(queue_en)
  );

  // R8: the command port never pops an empty queue
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !q_empty);

  // R10: a full queue with no drain that receives a byte flags overflow
  a_r10_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push && q_full && !pop) |=> ovf);
endmodule

// File: tb/sim_sync_rx_fifo.sv
module sim_sync_rx_fifo;
  localparam int CLK_P = 10;
  localparam int PH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic bit_ready, miso, irq, ovf;
  int applied = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sync_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .irq(irq), .ovf(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FIFO-check FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data  = b[i];
    end
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data  = b[i];
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] w, output logic [7:0] r);
    r = '0;
    @(negedge clk);
    csn = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      sck  = 1'b0;
      mosi = w[i];
      repeat (PH) @(negedge clk);
      if (i < 8) r[i] = miso;
      sck = 1'b1;
      repeat (PH) @(negedge clk);
    end
    sck = 1'b0;
    repeat (PH) @(negedge clk);
    csn = 1'b1;
    repeat (PH) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] w);
    logic [7:0] dummy;
    xfer(w, dummy);
  endtask

  task automatic rd_chk(input string req, input int exp);
    logic [7:0] r;
    xfer(16'hB000, r);
    chk(req, r, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      applied++;
      $display("FIFO-check FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R11 ready
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 miso", miso, 0);
    chk("R11 ready", bit_ready, 1);
    rd_chk("R8 disabled read", 0);

    // R3 arm: fill bit1, queue bit0
    wr(16'hCA03);
    for (int k = 0; k < 4; k++) send_byte(8'hFF);
    chk("R3 no store before sync", irq, 0);
    send_byte(8'h2D);
    send_byte(8'hD4);
    chk("R3 nothing stored by sync word", irq, 0);

    // R4 R7 R9 sweep all byte values through the queue
    for (int rnd = 0; rnd < 16; rnd++) begin
      for (int k = 0; k < 16; k++) send_byte(8'(rnd * 16 + k));
      chk("R9 irq with data", irq, 1);
      for (int k = 0; k < 16; k++) rd_chk("R4 R7 byte order", rnd * 16 + k);
      chk("R9 irq drained", irq, 0);
    end
    chk("R10 no overflow yet", ovf, 0);
    rd_chk("R8 empty read", 0);

    // R6 rewrite fill=1 while filling: still packing
    wr(16'hCA03);
    send_byte(8'h5C);
    rd_chk("R6 no restart on rewrite", 8'h5C);

    // R5 clear fill mid-byte
    send_bits(8'hF0, 4);
    wr(16'hCA01);
    send_byte(8'hA5);
    send_byte(8'hA5);
    chk("R5 stopped", irq, 0);

    // R6 clear then set starts a new search
    wr(16'hCA03);
    send_byte(8'h77);
    chk("R6 search after re-arm", irq, 0);
    send_byte(8'h2D);
    send_byte(8'hD4);
    send_byte(8'h3C);
    rd_chk("R6 data after new match", 8'h3C);

    // R2 new pattern byte
    wr(16'hCE5A);
    wr(16'hCA01);
    wr(16'hCA03);
    send_byte(8'h2D);
    send_byte(8'hD4);
    send_byte(8'h11);
    chk("R2 old pattern rejected", irq, 0);
    send_byte(8'h2D);
    send_byte(8'h5A);
    send_byte(8'h99);
    rd_chk("R2 new pattern accepted", 8'h99);

    // R12 unknown header changes nothing
    wr(16'hCF00);
    wr(16'hCA01);
    wr(16'hCA03);
    wr(16'h1203);
    send_byte(8'h2D);
    send_byte(8'h5A);
    send_byte(8'h42);
    rd_chk("R12 pattern kept", 8'h42);

    // R10 overflow
    for (int k = 0; k < 17; k++) send_byte(8'(8'h80 + k));
    chk("R10 ovf set", ovf, 1);
    chk("R9 irq full", irq, 1);
    for (int k = 0; k < 16; k++) rd_chk("R10 first sixteen kept", 8'h80 + k);
    rd_chk("R10 extra dropped", 0);
    chk("R10 ovf sticky", ovf, 1);

    // R8 queue disabled: zero, no pop
    send_byte(8'hE1);
    wr(16'hCA02);
    rd_chk("R8 disabled returns zero", 0);
    chk("R8 nothing removed", irq, 1);
    wr(16'hCA03);
    rd_chk("R8 byte still there", 8'hE1);
    chk("R9 irq after last read", irq, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule